// File: doc/BRIEF.md
# Flash Page Buffer Controller

This block owns the staging buffer that sits between a flash command interface and the program engine. The buffer is one page wide: 128 sixteen-bit words, which can also be addressed as 256 bytes. Four paths can fill it. A strict sequential page load takes one write per location in ascending order. A random single-location load takes one write at any column. A copy fetches a whole page from the array. A clear empties the buffer. A commit hands the buffer to the program engine. The engine reports completion, and the block then empties the buffer without further action.

The command interface decodes the command bytes and presents them as one-cycle strobes. Setup commands that need a confirm byte wait in an armed state until the confirm strobe arrives. Each byte lane has a valid mask. A byte that was never loaded reads back as erased (all ones), so the program engine can read the whole page through the read port without knowing which entries were written.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After reset, prog_req, seq_err and arr_rd_en are low, and every buffer word reads 16'hFFFF with rd_bvld equal to 2'b00.
- R2: On the read port, rd_bvld[0] covers the low byte (bits 7:0) and rd_bvld[1] covers the high byte (bits 15:8). A byte whose valid bit is clear reads 8'hFF.
- R3: In word mode (byte_mode=0), cmd_single_load followed by one data_wr stores wr_data at word index wr_addr[6:0] and sets both valid bits. Addresses may come in any order, and a later load to the same index overwrites the earlier one.
- R4: In byte mode, the data write address is a byte address. wr_addr[7:1] is the word index, and wr_addr[0]=1 selects the high byte (0 selects the low byte). The stored byte is wr_data[7:0], and only that byte's valid bit is set.
- R5: cmd_seq_load clears every valid bit. It then accepts 128 (word mode) or 256 (byte mode) data writes, whose addresses must be 0, 1, 2, … in order. prog_req goes high in the cycle after the last write is accepted.
- R6: During a sequential load, a write whose address does not equal the expected next one sets seq_err, clears every valid bit and ends the load without raising prog_req. seq_err stays high until the next cmd_seq_load.
- R7: cmd_flush followed by cmd_confirm raises prog_req. Any other strobe or write in between cancels the flush.
- R8: prog_req stays high until prog_done is sampled high. prog_req then drops in the next cycle, and every valid bit is cleared.
- R9: cmd_clear followed by cmd_confirm clears every valid bit.
- R10: cmd_copy followed by cmd_confirm starts a copy. For 128 consecutive cycles arr_rd_en is high and arr_col steps from 0 to 127. Each word is stored from arr_data with both valid bits set, and prog_req stays low.
- R11: Strobes and data writes are ignored while prog_req is high. A data write with no pending load is also ignored.
- R12: A cmd_confirm that has no pending setup command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing; held constant during an operation |
| cmd_seq_load | input | 1 | Strobe: start a sequential page load |
| cmd_single_load | input | 1 | Strobe: arm a single-location load |
| cmd_flush | input | 1 | Strobe: arm a buffer commit |
| cmd_clear | input | 1 | Strobe: arm a buffer clear |
| cmd_copy | input | 1 | Strobe: arm an array-page copy |
| cmd_confirm | input | 1 | Strobe: confirm the armed command |
| data_wr | input | 1 | Strobe: data write |
| wr_addr | input | 8 | Column address (word index in bits 6:0, or byte address) |
| wr_data | input | 16 | Write data (bits 7:0 in byte mode) |
| arr_rd_en | output | 1 | Copy in progress; array read request |
| arr_col | output | 7 | Column being read from the array |
| arr_data | input | 16 | Array word for arr_col, same cycle |
| prog_req | output | 1 | Commit request to the program engine |
| prog_done | input | 1 | Program engine has finished |
| seq_err | output | 1 | Sequential load address error |
| rd_idx | input | 7 | Buffer read index |
| rd_word | output | 16 | Buffer word, with unloaded bytes reading as 8'hFF |
| rd_bvld | output | 2 | Per-byte valid bits of the word at rd_idx |

## Verification
A wrong internal state shows up at the ports as follows:
- **Lost or misplaced byte:** if a byte write or a valid bit lands in the wrong place, the read port shows it at once. A loaded byte reads back as 8'hFF, or a foreign byte appears at another index, in the cycle after the write.
- **Wrong load counter:** prog_req rises one write too early or too late. Alternatively, an in-order write is rejected and seq_err rises in the cycle after that write.
- **Wrong armed or busy state:** a later strobe starts or cancels the wrong action. The result shows on prog_req, on arr_rd_en, or as a buffer that is cleared or left unchanged. It is visible one cycle after the confirm or after the stray strobe.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [2:0] {
    PB_IDLE,
    PB_SEQ,
    PB_SGL,
    PB_FLUSH_ARM,
    PB_CLEAR_ARM,
    PB_COPY_ARM,
    PB_COPY,
    PB_PROG
  } pb_state_e;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int WORDS = 128,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_we,
  input  logic [IW-1:0] st_idx,
  input  logic [1:0]    st_ben,
  input  logic [15:0]   st_wdata,
  input  logic          st_clr,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_word,
  output logic [1:0]    rd_bvld
);
  // one storage lane per byte of the word
  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [7:0]       mem [WORDS];
    logic [WORDS-1:0] vld;
    logic             lane_we;

    assign lane_we = st_we && st_ben[b];

    always_ff @(posedge clk) begin
      if (lane_we) mem[st_idx] <= st_wdata[b*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld <= '0;
      else if (st_clr)  vld <= '0;
      else if (lane_we) vld[st_idx] <= 1'b1;
    end

    assign rd_bvld[b]         = vld[rd_idx];
    assign rd_word[b*8 +: 8]  = vld[rd_idx] ? mem[rd_idx] : 8'hFF;
  end
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int IW = $clog2(WORDS),
  localparam int AW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          cmd_seq_load,
  input  logic          cmd_single_load,
  input  logic          cmd_flush,
  input  logic          cmd_clear,
  input  logic          cmd_copy,
  input  logic          cmd_confirm,
  input  logic          data_wr,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [15:0]   arr_data,
  input  logic          prog_done,
  output logic          st_we,
  output logic [IW-1:0] st_idx,
  output logic [1:0]    st_ben,
  output logic [15:0]   st_wdata,
  output logic          st_clr,
  output logic          prog_req,
  output logic          seq_err,
  output logic          arr_rd_en,
  output logic [IW-1:0] arr_col
);
  localparam logic [AW-1:0] LAST_W = AW'(WORDS - 1);
  localparam logic [AW-1:0] LAST_B = AW'(2 * WORDS - 1);
  localparam logic [IW-1:0] LAST_C = IW'(WORDS - 1);

  pb_state_e     st_q, st_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;

  logic          any_setup, any_other, in_order, last_load;
  logic [IW-1:0] w_idx;
  logic [1:0]    w_ben;
  logic [15:0]   w_dat;

  assign any_setup = cmd_seq_load | cmd_single_load | cmd_flush | cmd_clear | cmd_copy;
  assign any_other = any_setup | data_wr;
  assign w_idx     = byte_mode ? wr_addr[AW-1:1] : wr_addr[IW-1:0];
  assign w_ben     = byte_mode ? (wr_addr[0] ? 2'b10 : 2'b01) : 2'b11;
  assign w_dat     = byte_mode ? {2{wr_data[7:0]}} : wr_data;
  assign in_order  = byte_mode ? (wr_addr == cnt_q) : (wr_addr[IW-1:0] == cnt_q[IW-1:0]);
  assign last_load = byte_mode ? (cnt_q == LAST_B) : (cnt_q == LAST_W);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    st_we    = 1'b0;
    st_idx   = w_idx;
    st_ben   = w_ben;
    st_wdata = w_dat;
    st_clr   = 1'b0;
    unique case (st_q)
      PB_IDLE: begin
        if (cmd_seq_load) begin
          st_d = PB_SEQ; cnt_d = '0; err_d = 1'b0; st_clr = 1'b1;
        end else if (cmd_single_load) st_d = PB_SGL;
        else if (cmd_flush)           st_d = PB_FLUSH_ARM;
        else if (cmd_clear)           st_d = PB_CLEAR_ARM;
        else if (cmd_copy)            st_d = PB_COPY_ARM;
      end
      PB_SEQ: begin
        if (data_wr) begin
          if (in_order) begin
            st_we = 1'b1;
            cnt_d = cnt_q + 1'b1;
            if (last_load) st_d = PB_PROG;
          end else begin
            err_d = 1'b1; st_clr = 1'b1; st_d = PB_IDLE;
          end
        end
      end
      PB_SGL: begin
        if (data_wr) begin
          st_we = 1'b1; st_d = PB_IDLE;
        end else if (any_setup || cmd_confirm) st_d = PB_IDLE;
      end
      PB_FLUSH_ARM: begin
        if (cmd_confirm)    st_d = PB_PROG;
        else if (any_other) st_d = PB_IDLE;
      end
      PB_CLEAR_ARM: begin
        if (cmd_confirm) begin
          st_clr = 1'b1; st_d = PB_IDLE;
        end else if (any_other) st_d = PB_IDLE;
      end
      PB_COPY_ARM: begin
        if (cmd_confirm) begin
          st_d = PB_COPY; cnt_d = '0;
        end else if (any_other) st_d = PB_IDLE;
      end
      PB_COPY: begin
        st_we    = 1'b1;
        st_idx   = cnt_q[IW-1:0];
        st_ben   = 2'b11;
        st_wdata = arr_data;
        cnt_d    = cnt_q + 1'b1;
        if (cnt_q[IW-1:0] == LAST_C) st_d = PB_IDLE;
      end
      PB_PROG: begin
        if (prog_done) begin
          st_clr = 1'b1; st_d = PB_IDLE;
        end
      end
      default: st_d = PB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PB_IDLE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign prog_req  = (st_q == PB_PROG);
  assign arr_rd_en = (st_q == PB_COPY);
  assign arr_col   = cnt_q[IW-1:0];
  assign seq_err   = err_q;

  // R8
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && !prog_done |=> prog_req);
  // R8
  prog_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && prog_done |=> !prog_req);
  // R6
  err_noprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> !prog_req);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err && !cmd_seq_load |=> seq_err);
  // R10
  copy_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en && $past(arr_rd_en) |-> arr_col == IW'($past(arr_col) + 1'b1));
  // R10
  copy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |-> !prog_req);
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl #(
  parameter int WORDS = 128,
  localparam int IW = $clog2(WORDS),
  localparam int AW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          cmd_seq_load,
  input  logic          cmd_single_load,
  input  logic          cmd_flush,
  input  logic          cmd_clear,
  input  logic          cmd_copy,
  input  logic          cmd_confirm,
  input  logic          data_wr,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  output logic          arr_rd_en,
  output logic [IW-1:0] arr_col,
  input  logic [15:0]   arr_data,
  output logic          prog_req,
  input  logic          prog_done,
  output logic          seq_err,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_word,
  output logic [1:0]    rd_bvld
);
  logic          st_we, st_clr;
  logic [IW-1:0] st_idx;
  logic [1:0]    st_ben;
  logic [15:0]   st_wdata;

  pgbuf_seq #(.WORDS(WORDS)) u_seq (
    .clk, .rst_n, .byte_mode,
    .cmd_seq_load, .cmd_single_load, .cmd_flush, .cmd_clear, .cmd_copy, .cmd_confirm,
    .data_wr, .wr_addr, .wr_data, .arr_data, .prog_done,
    .st_we, .st_idx, .st_ben, .st_wdata, .st_clr,
    .prog_req, .seq_err, .arr_rd_en, .arr_col
  );

  pgbuf_store #(.WORDS(WORDS)) u_store (
    .clk, .rst_n, .st_we, .st_idx, .st_ben, .st_wdata, .st_clr,
    .rd_idx, .rd_word, .rd_bvld
  );
endmodule

// File: tb/pgbuf_ctrl_bench.sv
module pgbuf_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bm = 1'b0;
  logic        sq = 0, sg = 0, sf = 0, sc = 0, sp = 0, cf = 0, dw = 0, pd = 0;
  logic [7:0]  wa = '0;
  logic [15:0] wd = '0;
  logic [6:0]  ridx = '0;
  logic        arr_rd_en, prog_req, seq_err;
  logic [6:0]  arr_col;
  logic [15:0] arr_data, rd_word;
  logic [1:0]  rd_bvld;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_lo [128];
  logic [7:0] m_hi [128];
  bit         v_lo [128];
  bit         v_hi [128];

  always #4 clk = ~clk;

  function automatic logic [15:0] arr_fn(logic [6:0] c);
    return {c, 1'b1, ~c, 1'b0} ^ 16'h5A3C;
  endfunction
  assign arr_data = arr_fn(arr_col);

  pgbuf_ctrl u_pgbuf_ctrl (
    .clk, .rst_n, .byte_mode(bm),
    .cmd_seq_load(sq), .cmd_single_load(sg), .cmd_flush(sf), .cmd_clear(sc),
    .cmd_copy(sp), .cmd_confirm(cf), .data_wr(dw), .wr_addr(wa), .wr_data(wd),
    .arr_rd_en, .arr_col, .arr_data, .prog_req, .prog_done(pd), .seq_err,
    .rd_idx(ridx), .rd_word, .rd_bvld
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < 128; i++) begin v_lo[i] = 0; v_hi[i] = 0; end
  endtask

  task automatic m_write(logic [7:0] a, logic [15:0] d);
    if (bm) begin
      if (a[0]) begin m_hi[a[7:1]] = d[7:0]; v_hi[a[7:1]] = 1; end
      else      begin m_lo[a[7:1]] = d[7:0]; v_lo[a[7:1]] = 1; end
    end else begin
      m_lo[a[6:0]] = d[7:0]; v_lo[a[6:0]] = 1;
      m_hi[a[6:0]] = d[15:8]; v_hi[a[6:0]] = 1;
    end
  endtask

  function automatic logic [17:0] m_exp(int i);
    return {v_hi[i], v_lo[i], v_hi[i] ? m_hi[i] : 8'hFF, v_lo[i] ? m_lo[i] : 8'hFF};
  endfunction

  task automatic check_buf(string req);
    for (int i = 0; i < 128; i++) begin
      ridx = 7'(i);
      #0.5;
      check({rd_bvld, rd_word} == m_exp(i), req, {14'd0, rd_bvld, rd_word}, {14'd0, m_exp(i)});
    end
  endtask

  // k: 0 seq,1 single,2 flush,3 clear,4 copy,5 confirm
  task automatic strobe(int k);
    @(negedge clk);
    sq = (k == 0); sg = (k == 1); sf = (k == 2); sc = (k == 3); sp = (k == 4); cf = (k == 5);
    @(negedge clk);
    sq = 0; sg = 0; sf = 0; sc = 0; sp = 0; cf = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    dw = 1; wa = a; wd = d;
    @(negedge clk);
    dw = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); pd = 1;
    @(negedge clk); pd = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] a;
    logic [15:0] d;
    int n;
    void'($urandom(32'h1234_5678));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!prog_req && !seq_err && !arr_rd_en, "R1", {prog_req, seq_err, arr_rd_en}, 0);
    check_buf("R1");

    // R3 random single word loads
    bm = 0;
    for (int i = 0; i < 40; i++) begin
      a = 8'($urandom % 128); d = 16'($urandom);
      strobe(1); wr(a, d); m_write(a, d);
    end
    check_buf("R3");

    // R9 clear
    strobe(3); strobe(5); m_clear();
    check_buf("R9");

    // R2 directed: high byte only at index 2
    bm = 1;
    strobe(1); wr(8'h05, 16'h003C); m_write(8'h05, 16'h003C);
    ridx = 7'd2; #0.5;
    check(rd_word == 16'h3CFF && rd_bvld == 2'b10, "R2", {rd_bvld, rd_word}, {2'b10, 16'h3CFF});

    // R4 random byte loads
    for (int i = 0; i < 60; i++) begin
      a = 8'($urandom); d = 16'($urandom);
      strobe(1); wr(a, d); m_write(a, d);
    end
    check_buf("R4");

    // R12 stray confirm, R11 write in idle
    strobe(5);
    wr(8'h10, 16'hBEEF);
    check_buf("R12");
    check(!prog_req, "R11", prog_req, 0);

    // R7 cancel, then real flush
    strobe(2); strobe(1); strobe(5);
    check(!prog_req, "R7", prog_req, 0);
    strobe(2); strobe(3); strobe(5);
    check(!prog_req, "R7", prog_req, 0);
    check_buf("R7");
    strobe(2); strobe(5);
    check(prog_req, "R7", prog_req, 1);

    // R11 ignored while committing
    strobe(1); wr(8'h20, 16'h1234); strobe(3); strobe(5);
    check(prog_req, "R8", prog_req, 1);
    check_buf("R11");
    done_pulse();
    check(!prog_req, "R8", prog_req, 0);
    m_clear();
    check_buf("R8");

    // R5 sequential word load
    bm = 0;
    strobe(0);
    for (int k = 0; k < 128; k++) begin
      d = 16'($urandom);
      if (k == 127) check(!prog_req, "R5", prog_req, 0);
      wr(8'(k), d); m_write(8'(k), d);
    end
    check(prog_req, "R5", prog_req, 1);
    check_buf("R5");
    done_pulse(); m_clear();

    // R5 sequential byte load
    bm = 1;
    strobe(0);
    for (int k = 0; k < 256; k++) begin
      d = 16'($urandom);
      wr(8'(k), d); m_write(8'(k), d);
    end
    check(prog_req, "R5", prog_req, 1);
    check_buf("R5");
    done_pulse(); m_clear();
    check_buf("R8");

    // R6 out of order
    bm = 0;
    strobe(1); wr(8'h40, 16'hAAAA);
    strobe(0); m_clear();
    n = 5 + int'($urandom % 100);
    for (int k = 0; k < n; k++) wr(8'(k), 16'($urandom));
    wr(8'(n + 1), 16'h7777);
    check(seq_err && !prog_req, "R6", {seq_err, prog_req}, 2'b10);
    check_buf("R6");
    wr(8'(n), 16'h1111);
    check(!prog_req, "R6", prog_req, 0);
    check_buf("R6");
    strobe(1); wr(8'h03, 16'hC0DE); m_write(8'h03, 16'hC0DE);
    check(seq_err, "R6", seq_err, 1);
    check_buf("R3");
    strobe(0); m_clear();
    check(!seq_err, "R6", seq_err, 0);
    wr(8'h01, 16'h0);
    check(seq_err, "R6", seq_err, 1);

    // R10 copy
    m_write(8'h00, 16'h0); m_clear();
    strobe(4); strobe(5);
    for (int k = 0; k < 128; k++) begin
      check(arr_rd_en && arr_col == 7'(k) && !prog_req, "R10", {arr_rd_en, arr_col}, {1'b1, 7'(k)});
      m_lo[k] = arr_fn(7'(k)) >> 0; m_hi[k] = 8'(arr_fn(7'(k)) >> 8);
      v_lo[k] = 1; v_hi[k] = 1;
      @(negedge clk);
    end
    check(!arr_rd_en && !prog_req, "R10", {arr_rd_en, prog_req}, 0);
    check_buf("R10");

    finish_run();
  end
endmodule